// File: doc/BRIEF.md
# Sign-Extension-Aware Gated Sample Register

This block stores one two's-complement sample of N+1 bits, where bit N is the sign and the N bits below it carry the magnitude. The magnitude is cut into P equal slices of M = N/P bits. Slice 0 holds the least significant bits and is loaded on every clock. The sign bit is also loaded on every clock. Each higher slice has its own load enable. That enable is off when the slice, and every slice above it, holds nothing but copies of the sign bit.

The enables are worked out combinationally from the sample waiting at the input and the sign already stored. They are ready during the cycle before the edge that captures that sample, so a clock-gating cell can use them directly. A change of sign between the stored value and the incoming value turns every enable on.

A slice that was skipped keeps stale bits. On the output, each such slice is replaced by copies of the stored sign, so the output always equals the last sample captured. The block suits a datapath in which one narrow-band signal feeds many consumers.

Top module: `subword_gated_reg`

## Requirements
- R1: While reset (active low) is asserted, and after it is released until the first capture, `dout` reads zero.
- R2: After each rising clock edge out of reset, `dout` equals the `din` value present at that edge, for every input value.
- R3: `sub_en[0]` is always 1.
- R4: When `din[N]` is 0 and equals the stored sign `dout[N]`, `sub_en[i]` for i ≥ 1 is 1 exactly when some bit of `din[N-1:i*M]` is 1.
- R5: When `din[N]` is 1 and equals the stored sign `dout[N]`, `sub_en[i]` for i ≥ 1 is 1 exactly when some bit of `din[N-1:i*M]` is 0.
- R6: When `din[N]` differs from the stored sign `dout[N]`, every bit of `sub_en` is 1.
- R7: `sub_en` is a thermometer code: if `sub_en[i]` is 1, then every lower bit of `sub_en` is also 1.
- R8: A slice whose enable is 0 keeps its stored bits unchanged across that edge, and `dout` still reads the correctly sign-extended value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register captures on the rising edge |
| rst_n | input | 1 | Reset, active low, synchronous |
| din | input | N+1 | Incoming two's-complement sample; bit N is the sign |
| dout | output | N+1 | Stored sample, with skipped slices shown as sign extension |
| sub_en | output | P | Load enable per magnitude slice for the waiting sample; bit i belongs to slice i |

## Verification
The bench uses a configuration with N=6 and P=3. It steps through every ordered pair of a stored 7-bit value and an incoming 7-bit value. Pairs with the same sign but different magnitudes test the zero-detect rule for positive values and the ones-detect rule for negative values at each slice boundary. Pairs that cross between the two signs show that a sign change forces every enable on, even when both values are small. Read-back of the output after each capture shows that skipping a slice never corrupts the stored value.

// File: rtl/subword_gated_reg.sv
module subword_gated_reg #(
  parameter int N = 12,
  parameter int P = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N:0]   din,
  output logic [N:0]   dout,
  output logic [P-1:0] sub_en
);
  localparam int M = N / P;

  if ((P < 2) || (N % P != 0)) begin : g_bad_cfg
    $error("subword_gated_reg: N must be a multiple of P and P must be at least 2");
  end

  logic         sign_q;
  logic [N-1:0] mag_q;
  logic [P-1:0] act_q;
  logic [P-1:0] idle_raw;
  logic [P-1:0] idle;
  logic         flip;

  assign flip = din[N] ^ sign_q;

  for (genvar g = 0; g < P; g++) begin : g_slice
    assign idle_raw[g] = din[N] ? (&din[g*M +: M]) : ~(|din[g*M +: M]);
    if (g == 0) begin : g_lsb
      assign idle[g] = 1'b0;
    end else if (g == P-1) begin : g_top
      assign idle[g] = idle_raw[g] & ~flip;
    end else begin : g_mid
      assign idle[g] = idle_raw[g] & idle[g+1];
    end
    assign dout[g*M +: M] = act_q[g] ? mag_q[g*M +: M] : {M{sign_q}};
  end

  assign sub_en  = ~idle;
  assign dout[N] = sign_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sign_q <= 1'b0;
      mag_q  <= '0;
      act_q  <= '0;
    end else begin
      sign_q <= din[N];
      act_q  <= sub_en;
      for (int i = 0; i < P; i++) begin
        if (sub_en[i]) mag_q[i*M +: M] <= din[i*M +: M];
      end
    end
  end

  logic primed;
  always_ff @(posedge clk) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R2
  capture_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> dout == $past(din));

  // R6
  sign_flip_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (din[N] != dout[N]) |-> (&sub_en));

  // R7
  thermometer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_en & (sub_en + 1'b1)) == '0);

  // R4
  top_idle_is_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_en[P-1] |-> din[N-1 -: M] == {M{din[N]}});

  // R8
  top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_en[P-1] |=> $stable(mag_q[N-1 -: M]));
endmodule

// File: tb/tb_subword_gated_reg.sv
module tb_subword_gated_reg;
  localparam int N = 6;
  localparam int P = 3;
  localparam int M = N / P;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N:0]   din = '0;
  logic [N:0]   dout;
  logic [P-1:0] sub_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  subword_gated_reg #(.N(N), .P(P)) dut (
    .clk(clk), .rst_n(rst_n), .din(din), .dout(dout), .sub_en(sub_en)
  );

  function automatic logic [P-1:0] model_en(logic [N:0] v, logic stored_sign);
    logic [P-1:0] e;
    for (int i = 0; i < P; i++) begin
      if (i == 0 || v[N] != stored_sign) e[i] = 1'b1;
      else begin
        e[i] = 1'b0;
        for (int b = i*M; b < N; b++) if (v[b] != v[N]) e[i] = 1'b1;
      end
    end
    return e;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    din = 7'h55;
    @(negedge clk);
    // R1
    chk(dout == '0, "R1 in reset", dout, 0);
    rst_n = 1'b1;
    din = '0;
    #1;
    chk(dout == '0, "R1 after release", dout, 0);
    for (int prev = 0; prev < (1 << (N+1)); prev++) begin
      for (int cur = 0; cur < (1 << (N+1)); cur++) begin
        logic [N:0] p, c;
        logic [P-1:0] e;
        string tag;
        p = prev[N:0];
        c = cur[N:0];
        @(negedge clk);
        din = p;
        @(negedge clk);
        // R2
        chk(dout == p, "R2 capture", dout, p);
        din = c;
        #1;
        e = model_en(c, p[N]);
        if (c[N] != p[N]) tag = "R6 sign change";
        else if (c[N])    tag = "R5 negative";
        else              tag = "R4 positive";
        chk(sub_en == e, tag, sub_en, e);
        // R3
        chk(sub_en[0] == 1'b1, "R3 lsb always", sub_en[0], 1);
        // R7
        chk((sub_en & (sub_en + 1'b1)) == '0, "R7 thermometer", sub_en, e);
        @(negedge clk);
        // R8
        chk(dout == c, (e != '1) ? "R8 skipped slice" : "R2 capture", dout, c);
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule